// File: doc/BRIEF.md
# Exit-Counting Fetch Sequencer

This block lets a conventional fetch unit fetch a whole predicated region with a single exit prediction. A region has one entry and several exit branches, and it always ends on a taken branch. An external exit predictor is given the region's start address. It returns the ordinal of the branch expected to leave the region and the address to go to next. The sequencer then steps the fetch address linearly, counting the branches that pre-decode marks. When the count reaches the predicted ordinal, it jumps to the predicted target and asks for the next prediction.

On the execute side a second counter numbers the resolved branches of the oldest region still in flight. When a branch actually resolves taken, that count is the real exit. It is sent out as a predictor update together with the region's start address. If it differs from the exit that was predicted for that region, a misprediction is raised. The fetch address is then forced to the resolved target, and every prediction that is queued or still in flight is thrown away. A small queue holds the start addresses and predicted exits of regions that have been fetched but not yet resolved, and fetch stalls at a region boundary when this queue is full.

Top module: `esq_fetch_seq`

## Requirements
- R1: After reset, fe_valid, up_valid and mispredict are 0, and pq_valid is 1 with pq_pc equal to RESET_PC.
- R2: Once raised, pq_valid stays high with pq_pc unchanged until pq_ready is seen high, unless a misprediction redirects it. After an accepted request no further request is made until the response has been taken.
- R3: fe_valid is 0 from an accepted request until the cycle after pr_valid. In that following cycle fe_valid is 1 and fe_pc still equals the requested region address.
- R4: While fetching, each fetch cycle that is not at the predicted exit advances fe_pc by STEP in the next cycle.
- R5: Branches marked by fe_branch are numbered from 0 within a region. In the fetch cycle whose branch number equals the predicted exit, the next cycle shows fe_valid 0, fe_pc equal to the predicted target, and a request for that address.
- R6: A cycle with ex_valid, ex_branch and ex_taken all high produces, one cycle later, up_valid 1. up_exit then equals the number of branches resolved since the previous taken branch (3 bits, counting from 0), and up_pc equals the start address of the oldest unresolved region, or 0 if there is none.
- R7: If that exit differs from the oldest unresolved region's predicted exit, or no region is queued, mispredict is 1 in the same cycle as up_valid. redirect_pc and fe_pc then equal ex_target, and fe_valid is 0.
- R8: A misprediction empties the region queue. A prediction response that was requested before it, and not yet returned, is dropped. The next request is issued for ex_target.
- R9: When Q_DEPTH regions are predicted and unresolved, pq_valid stays 0, so fetch stalls at the next region boundary.
- R10: Execute cycles with ex_branch low, or with ex_valid low, change neither the execute count nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pq_valid | output | 1 | Prediction request valid |
| pq_ready | input | 1 | Predictor accepts request |
| pq_pc | output | ADDR_W | Region start address to predict |
| pr_valid | input | 1 | Prediction response valid |
| pr_exit | input | EXIT_W | Predicted exit ordinal |
| pr_target | input | ADDR_W | Predicted next region address |
| fe_valid | output | 1 | Fetch address valid this cycle |
| fe_pc | output | ADDR_W | Fetch address |
| fe_branch | input | 1 | Pre-decode: fetched slot is a branch |
| ex_valid | input | 1 | Execute slot valid |
| ex_branch | input | 1 | Executed slot is a branch |
| ex_taken | input | 1 | Executed branch resolved taken |
| ex_target | input | ADDR_W | Resolved target of executed branch |
| up_valid | output | 1 | Predictor update valid |
| up_pc | output | ADDR_W | Region start address for update |
| up_exit | output | EXIT_W | Actual exit ordinal |
| mispredict | output | 1 | Exit misprediction, redirect |
| redirect_pc | output | ADDR_W | Redirect address on misprediction |

## Verification
On every cycle the assertions check local timing rules. A request holds until it is accepted, fetch stays off while a request is pending, and a non-branch fetch slot steps the address. Every update follows a taken resolution, and every misprediction comes with an update and a matching redirect address. Whether the exit ordinal, the queued region address and the mismatch decision are right depends on history across many regions. Only the bench's reference model can show that, along with the dropping of stale responses after a flush and the stall on a full queue.

// File: rtl/esq_pkg.sv
package esq_pkg;
   typedef enum logic [1:0] {
      ST_REQ   = 2'd0,
      ST_WAIT  = 2'd1,
      ST_RUN   = 2'd2,
      ST_DRAIN = 2'd3
   } fetch_st_e;
endpackage

// File: rtl/esq_region_fifo.sv
module esq_region_fifo #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 32,
   parameter int EXIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_pc,
   input  logic [EXIT_W-1:0] push_exit,
   input  logic              pop,
   input  logic              clear,
   output logic              full,
   output logic              empty,
   output logic [ADDR_W-1:0] head_pc,
   output logic [EXIT_W-1:0] head_exit
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("esq_region_fifo: DEPTH must be a power of two");
   end

   if (DEPTH == 1) begin : g_single
      logic              vld_q;
      logic [ADDR_W-1:0] pc_q;
      logic [EXIT_W-1:0] ex_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            vld_q <= 1'b0;
            pc_q  <= '0;
            ex_q  <= '0;
         end else if (push) begin
            vld_q <= 1'b1;
            pc_q  <= push_pc;
            ex_q  <= push_exit;
         end else if (pop) begin
            vld_q <= 1'b0;
         end
      end
      assign full      = vld_q;
      assign empty     = !vld_q;
      assign head_pc   = pc_q;
      assign head_exit = ex_q;
   end else begin : g_ring
      logic [ADDR_W-1:0] pc_mem [DEPTH];
      logic [EXIT_W-1:0] ex_mem [DEPTH];
      logic [PW-1:0]     wptr_q, rptr_q;
      logic [CW-1:0]     cnt_q;
      logic              do_pop;

      assign do_pop = pop && (cnt_q != '0);

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
         end else begin
            if (push) wptr_q <= wptr_q + PW'(1);
            if (do_pop) rptr_q <= rptr_q + PW'(1);
            if (push && !do_pop) cnt_q <= cnt_q + CW'(1);
            else if (!push && do_pop) cnt_q <= cnt_q - CW'(1);
         end
      end

      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pc_mem[i] <= '0;
               ex_mem[i] <= '0;
            end else if (push && wptr_q == PW'(i)) begin
               pc_mem[i] <= push_pc;
               ex_mem[i] <= push_exit;
            end
         end
      end

      assign full      = (cnt_q == CW'(DEPTH));
      assign empty     = (cnt_q == '0);
      assign head_pc   = pc_mem[rptr_q];
      assign head_exit = ex_mem[rptr_q];
   end
endmodule

// File: rtl/esq_fetch_ctrl.sv
module esq_fetch_ctrl
   import esq_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                EXIT_W   = 3,
   parameter int                STEP     = 4,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_full,
   output logic              pq_valid,
   input  logic              pq_ready,
   output logic [ADDR_W-1:0] pq_pc,
   input  logic              pr_valid,
   input  logic [EXIT_W-1:0] pr_exit,
   input  logic [ADDR_W-1:0] pr_target,
   output logic              fe_valid,
   output logic [ADDR_W-1:0] fe_pc,
   input  logic              fe_branch,
   input  logic              flush,
   input  logic [ADDR_W-1:0] flush_pc,
   output logic              push,
   output logic [ADDR_W-1:0] push_pc,
   output logic [EXIT_W-1:0] push_exit
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("esq_fetch_ctrl: STEP must be positive");
   end

   fetch_st_e         state_q, state_d;
   logic [ADDR_W-1:0] fpc_q, fpc_d;
   logic [ADDR_W-1:0] rpc_q;
   logic [ADDR_W-1:0] ptgt_q;
   logic [EXIT_W-1:0] pexit_q;
   logic [EXIT_W-1:0] fcnt_q, fcnt_d;
   logic              fire, at_exit;

   assign pq_valid  = (state_q == ST_REQ) && !q_full;
   assign pq_pc     = fpc_q;
   assign fe_valid  = (state_q == ST_RUN);
   assign fe_pc     = fpc_q;
   assign fire      = pq_valid && pq_ready;
   assign at_exit   = fe_valid && fe_branch && (fcnt_q == pexit_q);
   assign push      = (state_q == ST_WAIT) && pr_valid && !flush;
   assign push_pc   = rpc_q;
   assign push_exit = pr_exit;

   always_comb begin
      state_d = state_q;
      fpc_d   = fpc_q;
      fcnt_d  = fcnt_q;
      if (flush) begin
         fpc_d  = flush_pc;
         fcnt_d = '0;
         unique case (state_q)
            ST_REQ:   state_d = fire ? ST_DRAIN : ST_REQ;
            ST_WAIT:  state_d = pr_valid ? ST_REQ : ST_DRAIN;
            ST_RUN:   state_d = ST_REQ;
            ST_DRAIN: state_d = pr_valid ? ST_REQ : ST_DRAIN;
            default:  state_d = ST_REQ;
         endcase
      end else begin
         unique case (state_q)
            ST_REQ: if (fire) state_d = ST_WAIT;
            ST_WAIT: if (pr_valid) begin
               state_d = ST_RUN;
               fcnt_d  = '0;
            end
            ST_RUN: if (at_exit) begin
               state_d = ST_REQ;
               fpc_d   = ptgt_q;
               fcnt_d  = '0;
            end else begin
               fpc_d = fpc_q + STEP_V;
               if (fe_branch) fcnt_d = fcnt_q + EXIT_W'(1);
            end
            ST_DRAIN: if (pr_valid) state_d = ST_REQ;
            default: state_d = ST_REQ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_REQ;
         fpc_q   <= RESET_PC;
         fcnt_q  <= '0;
         rpc_q   <= RESET_PC;
         ptgt_q  <= '0;
         pexit_q <= '0;
      end else begin
         state_q <= state_d;
         fpc_q   <= fpc_d;
         fcnt_q  <= fcnt_d;
         if (fire && !flush) rpc_q <= fpc_q;
         if (push) begin
            ptgt_q  <= pr_target;
            pexit_q <= pr_exit;
         end
      end
   end
endmodule

// File: rtl/esq_exec_track.sv
module esq_exec_track #(
   parameter int ADDR_W = 32,
   parameter int EXIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ex_valid,
   input  logic              ex_branch,
   input  logic              ex_taken,
   input  logic [ADDR_W-1:0] ex_target,
   input  logic              q_empty,
   input  logic [ADDR_W-1:0] head_pc,
   input  logic [EXIT_W-1:0] head_exit,
   output logic              pop,
   output logic              flush,
   output logic              up_valid,
   output logic [ADDR_W-1:0] up_pc,
   output logic [EXIT_W-1:0] up_exit,
   output logic              mispredict,
   output logic [ADDR_W-1:0] redirect_pc
);
   logic [EXIT_W-1:0] ecnt_q;
   logic              br_seen, br_taken, exit_match;

   assign br_seen    = ex_valid && ex_branch;
   assign br_taken   = br_seen && ex_taken;
   assign exit_match = !q_empty && (head_exit == ecnt_q);
   assign pop        = br_taken && exit_match;
   assign flush      = br_taken && !exit_match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ecnt_q      <= '0;
         up_valid    <= 1'b0;
         up_pc       <= '0;
         up_exit     <= '0;
         mispredict  <= 1'b0;
         redirect_pc <= '0;
      end else begin
         up_valid   <= br_taken;
         mispredict <= flush;
         if (br_taken) begin
            ecnt_q  <= '0;
            up_exit <= ecnt_q;
            up_pc   <= q_empty ? '0 : head_pc;
         end else if (br_seen) begin
            ecnt_q <= ecnt_q + EXIT_W'(1);
         end
         if (flush) redirect_pc <= ex_target;
      end
   end
endmodule

// File: rtl/esq_fetch_seq.sv
module esq_fetch_seq #(
   parameter int                ADDR_W   = 32,
   parameter int                EXIT_W   = 3,
   parameter int                STEP     = 4,
   parameter int                Q_DEPTH  = 4,
   parameter logic [ADDR_W-1:0] RESET_PC = 'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              pq_valid,
   input  logic              pq_ready,
   output logic [ADDR_W-1:0] pq_pc,
   input  logic              pr_valid,
   input  logic [EXIT_W-1:0] pr_exit,
   input  logic [ADDR_W-1:0] pr_target,
   output logic              fe_valid,
   output logic [ADDR_W-1:0] fe_pc,
   input  logic              fe_branch,
   input  logic              ex_valid,
   input  logic              ex_branch,
   input  logic              ex_taken,
   input  logic [ADDR_W-1:0] ex_target,
   output logic              up_valid,
   output logic [ADDR_W-1:0] up_pc,
   output logic [EXIT_W-1:0] up_exit,
   output logic              mispredict,
   output logic [ADDR_W-1:0] redirect_pc
);
   if (ADDR_W < 2 || EXIT_W < 1) begin : g_bad_width
      $error("esq_fetch_seq: ADDR_W and EXIT_W too small");
   end

   logic              q_push, q_pop, q_full, q_empty, flush;
   logic [ADDR_W-1:0] q_push_pc, q_head_pc;
   logic [EXIT_W-1:0] q_push_exit, q_head_exit;

   esq_fetch_ctrl #(
      .ADDR_W(ADDR_W), .EXIT_W(EXIT_W), .STEP(STEP), .RESET_PC(RESET_PC)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .q_full(q_full),
      .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_pc(pq_pc),
      .pr_valid(pr_valid), .pr_exit(pr_exit), .pr_target(pr_target),
      .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_branch(fe_branch),
      .flush(flush), .flush_pc(ex_target),
      .push(q_push), .push_pc(q_push_pc), .push_exit(q_push_exit)
   );

   esq_region_fifo #(
      .DEPTH(Q_DEPTH), .ADDR_W(ADDR_W), .EXIT_W(EXIT_W)
   ) u_regq (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_pc(q_push_pc), .push_exit(q_push_exit),
      .pop(q_pop), .clear(flush),
      .full(q_full), .empty(q_empty),
      .head_pc(q_head_pc), .head_exit(q_head_exit)
   );

   esq_exec_track #(
      .ADDR_W(ADDR_W), .EXIT_W(EXIT_W)
   ) u_exec (
      .clk(clk), .rst_n(rst_n),
      .ex_valid(ex_valid), .ex_branch(ex_branch), .ex_taken(ex_taken),
      .ex_target(ex_target),
      .q_empty(q_empty), .head_pc(q_head_pc), .head_exit(q_head_exit),
      .pop(q_pop), .flush(flush),
      .up_valid(up_valid), .up_pc(up_pc), .up_exit(up_exit),
      .mispredict(mispredict), .redirect_pc(redirect_pc)
   );
endmodule

// File: rtl/esq_chk.sv
module esq_chk #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pq_valid,
   input logic              pq_ready,
   input logic [ADDR_W-1:0] pq_pc,
   input logic              fe_valid,
   input logic [ADDR_W-1:0] fe_pc,
   input logic              fe_branch,
   input logic              ex_valid,
   input logic              ex_branch,
   input logic              ex_taken,
   input logic              up_valid,
   input logic              mispredict,
   input logic [ADDR_W-1:0] redirect_pc
);
   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pq_valid && !pq_ready |=> pq_valid && ($stable(pq_pc) || mispredict));

   // R3
   stall_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pq_valid |-> !fe_valid);

   // R4
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_valid && !fe_branch |=> mispredict ||
         (fe_valid && fe_pc == $past(fe_pc) + ADDR_W'(STEP)));

   // R6
   update_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> $past(ex_valid && ex_branch && ex_taken));

   // R7
   mispred_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> up_valid);

   // R7
   mispred_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> (fe_pc == redirect_pc) && !fe_valid);
endmodule

bind esq_fetch_seq esq_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_esq_chk (
   .clk(clk), .rst_n(rst_n), .pq_valid(pq_valid), .pq_ready(pq_ready),
   .pq_pc(pq_pc), .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_branch(fe_branch),
   .ex_valid(ex_valid), .ex_branch(ex_branch), .ex_taken(ex_taken),
   .up_valid(up_valid), .mispredict(mispredict), .redirect_pc(redirect_pc)
);

// File: tb/esq_fetch_seq_bench.sv
module esq_fetch_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int QD = 4;
   localparam logic [31:0] RPC = 32'h1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        pq_valid, pq_ready, pr_valid, fe_valid, fe_branch;
   logic [31:0] pq_pc, pr_target, fe_pc, ex_target, up_pc, redirect_pc;
   logic [2:0]  pr_exit, up_exit;
   logic        ex_valid, ex_branch, ex_taken, up_valid, mispredict;

   esq_fetch_seq #(.ADDR_W(32), .EXIT_W(3), .STEP(4), .Q_DEPTH(QD), .RESET_PC(RPC))
   u_esq_fetch_seq (
      .clk(clk), .rst_n(rst_n), .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_pc(pq_pc),
      .pr_valid(pr_valid), .pr_exit(pr_exit), .pr_target(pr_target),
      .fe_valid(fe_valid), .fe_pc(fe_pc), .fe_branch(fe_branch),
      .ex_valid(ex_valid), .ex_branch(ex_branch), .ex_taken(ex_taken), .ex_target(ex_target),
      .up_valid(up_valid), .up_pc(up_pc), .up_exit(up_exit),
      .mispredict(mispredict), .redirect_pc(redirect_pc));

   int nchk = 0, nfail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
      end
   endtask

   // reference model state (0 request, 1 wait, 2 fetch, 3 drain)
   int          m_state = 0;
   logic [31:0] m_fpc = RPC, m_rpc = RPC, m_ptgt = 0;
   int          m_fcnt = 0, m_pexit = 0, m_ecnt = 0;
   logic [31:0] q_pc[$];
   int          q_exit[$];
   bit          m_upv = 0, m_mis = 0;
   logic [31:0] m_upp = 0, m_rdp = 0;
   int          m_upe = 0;
   // behavioural predictor
   bit          pend = 0;
   int          pend_wait = 0;
   logic [31:0] pend_pc = 0;
   int unsigned rng = 32'h1234_5678;

   function automatic int unsigned nxt();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   function automatic int exit_of(logic [31:0] pc);
      return int'(((pc >> 2) ^ (pc >> 5)) % 5);
   endfunction
   function automatic logic [31:0] tgt_of(logic [31:0] pc);
      return 32'h1000 + ((((pc >> 2) * 7) + 3) % 48) * 4;
   endfunction

   initial begin
      pq_ready = 0; pr_valid = 0; pr_exit = 0; pr_target = 0; fe_branch = 0;
      ex_valid = 0; ex_branch = 0; ex_taken = 0; ex_target = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(pq_valid === 1'b1, "R1 pq_valid after reset", 32'(pq_valid), 1);
      chk(pq_pc === RPC, "R1 pq_pc after reset", pq_pc, RPC);
      chk(fe_valid === 1'b0, "R1 fe_valid after reset", 32'(fe_valid), 0);
      chk(up_valid === 1'b0 && mispredict === 1'b0, "R1 update/mispredict after reset",
          {30'd0, up_valid, mispredict}, 0);
      for (int cyc = 0; cyc < 4000; cyc++) begin
         bit mpqv, fire, taken, hit, mis;
         int lat, r;
         // compare every output against the model
         mpqv = (m_state == 0) && (q_pc.size() < QD);
         chk(pq_valid === mpqv, "R2 R9 pq_valid", 32'(pq_valid), 32'(mpqv));
         chk(pq_pc === m_fpc, "R5 R8 pq_pc", pq_pc, m_fpc);
         chk(fe_valid === (m_state == 2), "R3 R8 fe_valid", 32'(fe_valid), 32'(m_state == 2));
         chk(fe_pc === m_fpc, "R4 R5 fe_pc", fe_pc, m_fpc);
         chk(up_valid === m_upv, "R6 R10 up_valid", 32'(up_valid), 32'(m_upv));
         chk(up_pc === m_upp, "R6 up_pc", up_pc, m_upp);
         chk(up_exit === 3'(m_upe), "R6 R10 up_exit", 32'(up_exit), 32'(m_upe));
         chk(mispredict === m_mis, "R7 mispredict", 32'(mispredict), 32'(m_mis));
         chk(redirect_pc === m_rdp, "R7 redirect_pc", redirect_pc, m_rdp);
         if (cyc == 110) chk(pq_valid === 1'b0 && q_pc.size() == QD,
                             "R9 stall with full queue", 32'(pq_valid), 0);
         // drive inputs
         lat = (cyc < 120) ? 1 : 1 + int'(nxt() % 3);
         pq_ready = (cyc < 120) ? 1'b1 : nxt() % 4 != 0;
         pr_valid = 0;
         if (pend) begin
            pend_wait--;
            if (pend_wait == 0) begin
               pr_valid = 1; pr_exit = 3'(exit_of(pend_pc)); pr_target = tgt_of(pend_pc); pend = 0;
            end
         end
         fe_branch = ((m_fpc >> 2) % 3) != 0;
         ex_valid = 0; ex_branch = 0; ex_taken = 0; ex_target = 0;
         if (cyc >= 120) begin
            r = int'(nxt() % 16);
            if (q_exit.size() == 0) begin
               if (cyc >= 1500 && r == 0) begin
                  ex_valid = 1; ex_branch = 1; ex_taken = 1;
               end
            end else if (r >= 4 && r < 6) begin
               ex_valid = 1; ex_branch = 0; ex_taken = 1;       // R10 non-branch ignored
            end else if (r == 6) begin
               ex_valid = 0; ex_branch = 1; ex_taken = 1;       // R10 invalid slot ignored
            end else if (r >= 7) begin
               ex_valid = 1; ex_branch = 1;
               ex_taken = (cyc >= 1500 && r == 15) ? 1'b1 : (m_ecnt == q_exit[0]);
            end
            ex_target = 32'h2000 + ((nxt() & 63) << 2);
         end
         // advance the model by one clock
         fire = mpqv && pq_ready;
         if (fire) begin pend = 1; pend_wait = lat; pend_pc = m_fpc; end
         taken = ex_valid && ex_branch && ex_taken;
         mis = 0;
         if (taken) begin
            hit = (q_exit.size() > 0) && (q_exit[0] == m_ecnt);
            m_upv = 1; m_upe = m_ecnt;
            m_upp = (q_pc.size() > 0) ? q_pc[0] : 32'h0;
            if (hit) begin
               void'(q_pc.pop_front()); void'(q_exit.pop_front()); m_mis = 0;
            end else begin
               mis = 1; m_mis = 1; m_rdp = ex_target; q_pc.delete(); q_exit.delete();
            end
            m_ecnt = 0;
         end else begin
            m_upv = 0; m_mis = 0;
            if (ex_valid && ex_branch) m_ecnt = (m_ecnt + 1) % 8;
         end
         if (mis) begin
            m_fpc = ex_target; m_fcnt = 0;
            case (m_state)
               0: m_state = fire ? 3 : 0;
               1: m_state = pr_valid ? 0 : 3;
               2: m_state = 0;
               default: m_state = pr_valid ? 0 : 3;
            endcase
         end else begin
            case (m_state)
               0: if (fire) begin m_rpc = m_fpc; m_state = 1; end
               1: if (pr_valid) begin
                     m_pexit = int'(pr_exit); m_ptgt = pr_target;
                     q_pc.push_back(m_rpc); q_exit.push_back(int'(pr_exit));
                     m_fcnt = 0; m_state = 2;
                  end
               2: if (fe_branch && m_fcnt == m_pexit) begin
                     m_fpc = m_ptgt; m_fcnt = 0; m_state = 0;
                  end else begin
                     m_fpc = m_fpc + 4;
                     if (fe_branch) m_fcnt++;
                  end
               default: if (pr_valid) m_state = 0;
            endcase
         end
         @(negedge clk);
      end
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired, actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule